// File: doc/BRIEF.md
# PCI Power Management Register Pair

This block holds the two configuration-space registers through which host software controls and inspects the power state of a PCI target function. One is the read-only capability word, which sits in the upper half of the dword at offset 40h (byte offset 42h). The other is the control/status word, which sits in the lower half of the dword at offset 44h. Configuration reads and writes arrive as dword accesses with byte enables. Read data is returned one clock after the read strobe.

A serial configuration loader can overwrite the preloadable capability fields and the data-scale field with a one-clock load strobe. A local request input raises the PME status flag. That flag then drives the active-low PME# output whenever the enable bit is also set.

Moving the function from D3hot back to D0 starts a local reset-and-reload sequence: a stretched local reset, a one-clock local power-management interrupt and a one-clock reload request. While the function is in D3hot, the block withdraws the gate that permits memory cycles, I/O cycles and interrupts.

Top module: `pm_cfg_regs`

## Requirements
- R1: After the synchronous reset, the following hold. The power state is 00 (D0) and `func_en_o` is 1. `pme_n_o` is 1. `lrst_o`, `lpm_irq_o` and `reload_o` are 0. The capability word reads 0001h (version 001). The control/status word reads 0000h.
- R2: The capability word occupies bits [31:16] of the dword at 40h, laid out as follows. Version is in [18:16]. The clock-needed flag is at 19. Device-specific initialization is at 21. PME from D0 is at 27. PME from D3hot is at 30. All other bits read 0, whatever the preload supplies for bits 12 and 13 of the support field. Bits [15:0] of that dword, and every dword other than 40h and 44h, read 0.
- R3: The power state is in control/status bits [1:0] (dword 44h, byte lane 0). Writing 00 (D0) or 11 (D3hot) is accepted and read back. `func_en_o` is 1 exactly while the state is D0.
- R4: A write of 01 or 10 to the state field is ignored. The field keeps its last legal value.
- R5: A write that moves the state from 11 to 00 drives `lpm_irq_o` and `reload_o` high for exactly one clock. They are high in the cycle after the write.
- R6: The same D3hot-to-D0 write holds `lrst_o` high for exactly 8 consecutive clocks, starting in the cycle after the write.
- R7: State writes other than D3hot-to-D0 produce no pulse on `lpm_irq_o`, `reload_o` or `lrst_o`. This covers D0-to-D3hot, D0-to-D0, D3hot-to-D3hot and illegal values.
- R8: Byte lane 1 of dword 44h writes PME enable (bit 8) and data select (bits [12:9]). Data scale (bits [14:13]) comes only from the preload and ignores PCI writes. A lane is written only when its byte enable is 1.
- R9: A high `pme_set_i` sets PME status (bit 15) only when the support bit for the current state is 1. The D0 support bit is capability bit 27 and the D3hot support bit is capability bit 30.
- R10: Writing 1 to bit 15 through lane 1 clears PME status. Writing 0 to it has no effect. A set and a clear in the same clock leave the status set.
- R11: `pme_n_o` is 0 exactly while PME status and PME enable are both 1.
- R12: The D3hot-to-D0 soft reset clears data select. PME enable and PME status are cleared only by the PCI reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high PCI reset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (bits [1:0] ignored) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| pl_load | input | 1 | Preload strobe from the serial loader |
| pl_version | input | 3 | Preloaded version |
| pl_clk_req | input | 1 | Preloaded clock-needed flag |
| pl_dsi | input | 1 | Preloaded device-specific initialization flag |
| pl_pme_sup | input | 4 | Preloaded PME support bits [14:11]; only [0] and [3] are kept |
| pl_data_scale | input | 2 | Preloaded data scale |
| pme_set_i | input | 1 | Local PME request |
| pm_state_o | output | 2 | Current power state |
| func_en_o | output | 1 | Memory, I/O and interrupt enable gate |
| lrst_o | output | 1 | Local reset, 8 clocks |
| lpm_irq_o | output | 1 | Local power-management interrupt pulse |
| reload_o | output | 1 | Configuration reload request pulse |
| pme_n_o | output | 1 | Active-low PME# |

## Verification
The hardest case to reach from the ports is a PME set request and a PCI write-1 clear arriving in the same clock. The bench reaches it with a write task that can also raise `pme_set_i` on the same edge. The second hard case is a set request that must be rejected because of the current state. To reach it, the bench preloads support for D0 only, moves the function to D3hot, and then pulses the request. It also checks that the 8-clock reset stretch and the single interrupt and reload pulses appear only on a true D3hot-to-D0 write. To do that, it counts pulse cycles over a window after each kind of state write.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [1:0] PS_D0    = 2'b00;
  localparam logic [1:0] PS_D3HOT = 2'b11;
  localparam logic [5:0] DW_CAP   = 6'h10;  // byte 40h
  localparam logic [5:0] DW_CSR   = 6'h11;  // byte 44h

  typedef struct packed {
    logic [2:0] version;
    logic       clk_req;
    logic       dsi;
    logic       sup_d0;
    logic       sup_d3;
    logic [1:0] scale;
  } pm_preload_t;

  localparam pm_preload_t PRELOAD_RST = '{version: 3'b001, clk_req: 1'b0,
                                          dsi: 1'b0, sup_d0: 1'b0,
                                          sup_d3: 1'b0, scale: 2'b00};
endpackage

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_state,
  input  logic [1:0] wr_val,
  output logic [1:0] state_o,
  output logic       func_en_o,
  output logic       irq_o,
  output logic       reload_o,
  output logic       lrst_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(RST_CYC - 1);

  logic [1:0]    nxt;
  logic          legal, wake;
  logic [CW-1:0] cnt;

  always_comb begin
    legal = (wr_val == PS_D0) || (wr_val == PS_D3HOT);
    wake  = wr_state && legal && (state_o == PS_D3HOT) && (wr_val == PS_D0);
    nxt   = (wr_state && legal) ? wr_val : state_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o   <= PS_D0;
      func_en_o <= 1'b1;
      irq_o     <= 1'b0;
      reload_o  <= 1'b0;
      lrst_o    <= 1'b0;
      cnt       <= '0;
    end else begin
      state_o   <= nxt;
      func_en_o <= (nxt == PS_D0);
      irq_o     <= wake;
      reload_o  <= wake;
      if (wake) begin
        lrst_o <= 1'b1;
        cnt    <= CNT_INIT;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        lrst_o <= 1'b0;
      end
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (state_o == PS_D0) || (state_o == PS_D3HOT)); // R4
  AST_IRQ_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R5
  AST_IRQ_IN_LRST: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> lrst_o); // R6
  AST_IRQ_AFTER_D3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(state_o) == PS_D3HOT) && (state_o == PS_D0)); // R7
endmodule

// File: rtl/pm_pme_ctrl.sv
module pm_pme_ctrl
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] state,
  input  logic       sup_d0,
  input  logic       sup_d3,
  input  logic       pme_set,
  input  logic       en_wr,
  input  logic       en_val,
  input  logic       clr_wr,
  output logic       en_o,
  output logic       status_o,
  output logic       pme_n_o
);
  logic allow, st_nxt, en_nxt;

  always_comb begin
    allow  = (state == PS_D0) ? sup_d0 : sup_d3;
    st_nxt = (pme_set && allow) ? 1'b1 : (clr_wr ? 1'b0 : status_o);
    en_nxt = en_wr ? en_val : en_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= 1'b0;
      status_o <= 1'b0;
      pme_n_o  <= 1'b1;
    end else begin
      en_o     <= en_nxt;
      status_o <= st_nxt;
      pme_n_o  <= ~(st_nxt & en_nxt);
    end
  end

  AST_PME_SET_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o) |-> $past(pme_set && allow)); // R9
  AST_PME_CLR_ONLY_W1: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o) |-> $past(clr_wr)); // R10
  AST_PME_PIN: assert property (@(posedge clk) disable iff (rst)
    !pme_n_o |-> (en_o && status_o)); // R11
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_pkg::*;
#(
  parameter int RST_CYC = 8,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rd,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          pl_load,
  input  logic [2:0]    pl_version,
  input  logic          pl_clk_req,
  input  logic          pl_dsi,
  input  logic [3:0]    pl_pme_sup,
  input  logic [1:0]    pl_data_scale,
  input  logic          pme_set_i,
  output logic [1:0]    pm_state_o,
  output logic          func_en_o,
  output logic          lrst_o,
  output logic          lpm_irq_o,
  output logic          reload_o,
  output logic          pme_n_o
);
  localparam int DSEL_W = 4;

  pm_preload_t        pl_q;
  logic [DSEL_W-1:0]  dsel_q;
  logic               hit_cap, hit_csr, wr_csr;
  logic               pme_en, pme_st;
  logic [15:0]        cap_word, csr_word;
  logic [DW-1:0]      rd_mux;

  always_comb begin
    hit_cap = (cfg_addr[AW-1:2] == DW_CAP[AW-3:0]);
    hit_csr = (cfg_addr[AW-1:2] == DW_CSR[AW-3:0]);
    wr_csr  = cfg_wr && hit_csr;
  end

  // preloaded fields
  always_ff @(posedge clk) begin
    if (rst) begin
      pl_q <= PRELOAD_RST;
    end else if (pl_load) begin
      pl_q <= '{version: pl_version, clk_req: pl_clk_req, dsi: pl_dsi,
                sup_d0: pl_pme_sup[0], sup_d3: pl_pme_sup[3],
                scale: pl_data_scale};
    end
  end

  pm_state_ctrl #(.RST_CYC(RST_CYC)) u_state (
    .clk      (clk),
    .rst      (rst),
    .wr_state (wr_csr && cfg_be[0]),
    .wr_val   (cfg_wdata[1:0]),
    .state_o  (pm_state_o),
    .func_en_o(func_en_o),
    .irq_o    (lpm_irq_o),
    .reload_o (reload_o),
    .lrst_o   (lrst_o)
  );

  pm_pme_ctrl u_pme (
    .clk     (clk),
    .rst     (rst),
    .state   (pm_state_o),
    .sup_d0  (pl_q.sup_d0),
    .sup_d3  (pl_q.sup_d3),
    .pme_set (pme_set_i),
    .en_wr   (wr_csr && cfg_be[1]),
    .en_val  (cfg_wdata[8]),
    .clr_wr  (wr_csr && cfg_be[1] && cfg_wdata[15]),
    .en_o    (pme_en),
    .status_o(pme_st),
    .pme_n_o (pme_n_o)
  );

  // data select: PCI writable, cleared by the soft reset pulse
  always_ff @(posedge clk) begin
    if (rst || lpm_irq_o) begin
      dsel_q <= '0;
    end else if (wr_csr && cfg_be[1]) begin
      dsel_q <= cfg_wdata[12:9];
    end
  end

  always_comb begin
    cap_word = '0;
    cap_word[2:0] = pl_q.version;
    cap_word[3]   = pl_q.clk_req;
    cap_word[5]   = pl_q.dsi;
    cap_word[11]  = pl_q.sup_d0;
    cap_word[14]  = pl_q.sup_d3;
    csr_word = '0;
    csr_word[1:0]   = pm_state_o;
    csr_word[8]     = pme_en;
    csr_word[12:9]  = dsel_q;
    csr_word[14:13] = pl_q.scale;
    csr_word[15]    = pme_st;
    rd_mux = '0;
    if (hit_cap)      rd_mux[31:16] = cap_word;
    else if (hit_csr) rd_mux[15:0]  = csr_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  AST_GATE_OFF_D3: assert property (@(posedge clk) disable iff (rst)
    (pm_state_o == PS_D3HOT) |-> !func_en_o); // R3
  AST_DSEL_SOFT_CLR: assert property (@(posedge clk) disable iff (rst)
    lpm_irq_o |=> (dsel_q == '0) || $past(wr_csr && cfg_be[1])); // R12
endmodule

// File: tb/pm_cfg_regs_test.sv
module pm_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rd = 0, cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        pl_load = 0, pl_clk_req = 0, pl_dsi = 0;
  logic [2:0]  pl_version = 0;
  logic [3:0]  pl_pme_sup = 0;
  logic [1:0]  pl_data_scale = 0;
  logic        pme_set_i = 0;
  logic [1:0]  pm_state_o;
  logic        func_en_o, lrst_o, lpm_irq_o, reload_o, pme_n_o;

  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  pm_cfg_regs uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d, logic pset = 0);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d; pme_set_i = pset;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; pme_set_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  task automatic preload(logic [2:0] v, logic ck, logic ds, logic [3:0] sup, logic [1:0] sc);
    @(negedge clk);
    pl_load = 1; pl_version = v; pl_clk_req = ck; pl_dsi = ds;
    pl_pme_sup = sup; pl_data_scale = sc;
    @(negedge clk);
    pl_load = 0;
  endtask

  task automatic pulse_set();
    @(negedge clk);
    pme_set_i = 1;
    @(negedge clk);
    pme_set_i = 0;
  endtask

  // counts pulse cycles starting right after a state write
  task automatic write_state_count(logic [1:0] s, output int n_irq, output int n_rel, output int n_rst);
    wr(8'h44, 4'b0001, {30'd0, s});
    n_irq = 0; n_rel = 0; n_rst = 0;
    for (int i = 0; i < 16; i++) begin
      n_irq += lpm_irq_o; n_rel += reload_o; n_rst += lrst_o;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 state", pm_state_o, 0);
    chk("R1 func_en", func_en_o, 1);
    chk("R1 pme_n", pme_n_o, 1);
    chk("R1 pulses", {lrst_o, lpm_irq_o, reload_o}, 0);
    rd(8'h40, d); chk("R1 cap", d, 32'h0001_0000);
    rd(8'h44, d); chk("R1 csr", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    preload(3'b010, 1, 1, 4'b1111, 2'b11);
    rd(8'h40, d); chk("R2 cap layout", d, 32'h482A_0000);
    rd(8'h48, d); chk("R2 other dword", d, 32'h0);
    wr(8'h40, 4'b1111, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R2 cap read-only", d, 32'h482A_0000);
    rd(8'h44, d); chk("R8 scale from preload", d, 32'h0000_6000);
    wr(8'h44, 4'b0010, 32'h0000_7FFF);
    rd(8'h44, d); chk("R8 lane1 write, lane0 masked", d, 32'h0000_7F00);
    wr(8'h44, 4'b0000, 32'h0000_0003);
    rd(8'h44, d); chk("R8 no byte enable", d, 32'h0000_7F00);
  endtask

  task automatic t_states();
    logic [31:0] d;
    int a, b, c;
    write_state_count(2'b01, a, b, c);
    chk("R4 01 ignored", pm_state_o, 0);
    chk("R7 no pulse illegal", a + b + c, 0);
    write_state_count(2'b11, a, b, c);
    chk("R3 enter D3hot", pm_state_o, 3);
    chk("R3 gate off", func_en_o, 0);
    chk("R7 no pulse D0->D3", a + b + c, 0);
    write_state_count(2'b10, a, b, c);
    rd(8'h44, d); chk("R4 10 ignored", d[1:0], 3);
    write_state_count(2'b11, a, b, c);
    chk("R7 no pulse D3->D3", a + b + c, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    int a, b, c;
    wr(8'h44, 4'b0001, 32'h0);
    chk("R5 irq in next cycle", lpm_irq_o, 1);
    chk("R5 reload in next cycle", reload_o, 1);
    chk("R6 lrst starts", lrst_o, 1);
    a = 0; b = 0; c = 0;
    for (int i = 0; i < 16; i++) begin
      a += lpm_irq_o; b += reload_o; c += lrst_o;
      @(negedge clk);
    end
    chk("R5 irq one clock", a, 1);
    chk("R5 reload one clock", b, 1);
    chk("R6 lrst 8 clocks", c, 8);
    chk("R3 back to D0", {pm_state_o, func_en_o}, 3'b001);
    rd(8'h44, d); chk("R12 dsel cleared, en kept", d, 32'h0000_6100);
    write_state_count(2'b00, a, b, c);
    chk("R7 no pulse D0->D0", a + b + c, 0);
  endtask

  task automatic t_pme();
    logic [31:0] d;
    preload(3'b001, 0, 0, 4'b0001, 2'b00);
    pulse_set();
    chk("R9 set in D0", pme_n_o, 0);
    rd(8'h44, d); chk("R9 status bit", d[15], 1);
    wr(8'h44, 4'b0010, 32'h0000_0100);
    rd(8'h44, d); chk("R10 write 0 keeps", d[15], 1);
    wr(8'h44, 4'b0010, 32'h0000_0000);
    chk("R11 en off releases", pme_n_o, 1);
    wr(8'h44, 4'b0010, 32'h0000_0100);
    chk("R11 en on drives", pme_n_o, 0);
    wr(8'h44, 4'b0011, 32'h0000_8103);
    rd(8'h44, d); chk("R10 write 1 clears", d, 32'h0000_0103);
    chk("R11 pin high", pme_n_o, 1);
    pulse_set();
    rd(8'h44, d); chk("R9 no set in D3hot", d[15], 0);
    wr(8'h44, 4'b0001, 32'h0);
    repeat (12) @(negedge clk);
    wr(8'h44, 4'b0010, 32'h0000_8100, 1'b1);
    rd(8'h44, d); chk("R10 set wins over clear", d[15], 1);
    wr(8'h44, 4'b0001, 32'h3);
    wr(8'h44, 4'b0001, 32'h0);
    repeat (12) @(negedge clk);
    rd(8'h44, d); chk("R12 status and en survive soft reset", d[15:8], 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_states();
    t_wake();
    t_pme();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule